// File: doc/BRIEF.md
# Registered Bus Transceiver

This block connects two 16-bit buses, A and B, through storage. Each direction has its own bank of flip-flops, so a word can be held on the way from A to B while a different word is held on the way from B to A. The word is split into two byte lanes. For each direction, each lane has its own clock, its own active-low capture enable and its own active-low drive enable. The block can therefore act as one 16-bit transceiver or as two separate byte-wide transceivers.

A lane captures its source bus byte on a rising edge of an internal capture clock. That clock is the OR of the lane clock and its enable. A rising clock with the enable low captures. A high enable holds the clock high and blocks capture. If the enable rises while the clock is low, it produces a capture edge of its own.

When a lane's drive enable is low, the stored byte appears unchanged on the destination bus. When the drive enable is high, that part of the bus is released. Both buses are bidirectional pins. An asynchronous active-low reset clears every store.

Top module: `reg_bus_xcvr`

## Requirements
- R1: With a lane's capture enable low, a rising edge of that lane's clock loads the source byte into the store. For the A-to-B direction the source is the A bus; for B-to-A it is the B bus. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R2: While a lane's capture enable stays high, rising edges of its clock leave the stored byte unchanged.
- R3: While a lane's clock stays low, the store keeps its byte no matter how often the source data changes.
- R4: A low drive enable puts the stored byte on the destination lane without inversion: A-to-B onto the B bus, B-to-A onto the A bus.
- R5: A high drive enable leaves the destination lane at high impedance.
- R6: The clock, capture enable and drive enable of one lane have no effect on the store or the bus bits of the other lane.
- R7: The two directions share no state. In one lane, A-to-B may capture the byte that B-to-A is driving onto the A bus, and both directions may capture on the same edge, which exchanges the two stored bytes.
- R8: If a capture enable rises from low to high while its clock is low, the store captures the source byte present at that moment.
- R9: While reset is low, every store is zero. After reset is released the stores stay zero until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of all stores |
| clk_ab | input | 2 | Per-lane clock, A-to-B store |
| ce_ab_n | input | 2 | Per-lane active-low capture enable, A-to-B |
| oe_ab_n | input | 2 | Per-lane active-low drive enable onto the B bus |
| clk_ba | input | 2 | Per-lane clock, B-to-A store |
| ce_ba_n | input | 2 | Per-lane active-low capture enable, B-to-A |
| oe_ba_n | input | 2 | Per-lane active-low drive enable onto the A bus |
| a_io | inout | 16 | A bus: source of A-to-B, destination of B-to-A |
| b_io | inout | 16 | B bus: source of B-to-A, destination of A-to-B |

## Verification
Two things can happen in the same cycle of one lane. One direction can capture from a bus while the other direction is driving that same bus from its store. The bench provokes this by enabling both drive enables of a lane, releasing its own bus drivers, and raising both lane clocks on one edge with both capture enables low. A correct store takes the value the other direction held before the edge, so both buses must show the two old bytes exchanged. A design that shares state between directions, or that sees the other direction's new value, fails this check.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_LANE_W = 8;
  localparam int unsigned XCVR_LANES  = 2;
endpackage

// File: rtl/xcvr_gate.sv
// Effective capture clock of one store: high whenever the enable blocks
// capture, so a capture edge is a rise of the clock with the enable low, or
// a release of the enable while the clock is low.
module xcvr_gate (
  input  logic clk_i,
  input  logic ce_n_i,
  output logic gclk_o
);
  assign gclk_o = clk_i | ce_n_i;
endmodule

// File: rtl/xcvr_bank.sv
// One byte-lane store for one direction, with its drive request.
module xcvr_bank #(
  parameter int unsigned W = xcvr_pkg::XCVR_LANE_W
) (
  input  logic         rst_n,
  input  logic         clk_i,
  input  logic         ce_n_i,
  input  logic         oe_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         drive_o
);
  logic         gclk;
  logic [W-1:0] store_d;
  logic [W-1:0] store_q;

  xcvr_gate u_gate (
    .clk_i  (clk_i),
    .ce_n_i (ce_n_i),
    .gclk_o (gclk)
  );

  always_comb begin
    store_d = d_i;
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  assign q_o     = store_q;
  assign drive_o = ~oe_n_i;

  // R1: each capture edge stores what was on the source lane at that edge
  a_r1_capture: assert property (@(posedge gclk) disable iff (!rst_n)
    1'b1 |=> (store_q == $past(d_i)));

  // R2: enable high across two clock rises keeps the store unchanged
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ce_n_i && $past(ce_n_i)) |-> $stable(store_q));
endmodule

// File: rtl/xcvr_core.sv
// Both directions of every lane, with flat data-out and drive-request ports.
module xcvr_core #(
  parameter int unsigned LANE_W = xcvr_pkg::XCVR_LANE_W,
  parameter int unsigned LANES  = xcvr_pkg::XCVR_LANES,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input  logic              rst_n,
  input  logic [LANES-1:0]  clk_ab,
  input  logic [LANES-1:0]  ce_ab_n,
  input  logic [LANES-1:0]  oe_ab_n,
  input  logic [LANES-1:0]  clk_ba,
  input  logic [LANES-1:0]  ce_ba_n,
  input  logic [LANES-1:0]  oe_ba_n,
  input  logic [BUS_W-1:0]  a_in,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  ab_q,
  output logic [LANES-1:0]  ab_drive,
  output logic [BUS_W-1:0]  ba_q,
  output logic [LANES-1:0]  ba_drive
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_bank #(.W(LANE_W)) u_ab (
      .rst_n   (rst_n),
      .clk_i   (clk_ab[g]),
      .ce_n_i  (ce_ab_n[g]),
      .oe_n_i  (oe_ab_n[g]),
      .d_i     (a_in[g*LANE_W +: LANE_W]),
      .q_o     (ab_q[g*LANE_W +: LANE_W]),
      .drive_o (ab_drive[g])
    );
    xcvr_bank #(.W(LANE_W)) u_ba (
      .rst_n   (rst_n),
      .clk_i   (clk_ba[g]),
      .ce_n_i  (ce_ba_n[g]),
      .oe_n_i  (oe_ba_n[g]),
      .d_i     (b_in[g*LANE_W +: LANE_W]),
      .q_o     (ba_q[g*LANE_W +: LANE_W]),
      .drive_o (ba_drive[g])
    );
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
// Top: bidirectional bus pins around the two-direction core.
module reg_bus_xcvr #(
  parameter int unsigned LANE_W = xcvr_pkg::XCVR_LANE_W,
  parameter int unsigned LANES  = xcvr_pkg::XCVR_LANES,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input  logic              rst_n,
  input  logic [LANES-1:0]  clk_ab,
  input  logic [LANES-1:0]  ce_ab_n,
  input  logic [LANES-1:0]  oe_ab_n,
  input  logic [LANES-1:0]  clk_ba,
  input  logic [LANES-1:0]  ce_ba_n,
  input  logic [LANES-1:0]  oe_ba_n,
  inout  wire  [BUS_W-1:0]  a_io,
  inout  wire  [BUS_W-1:0]  b_io
);
  logic [BUS_W-1:0] ab_q;
  logic [BUS_W-1:0] ba_q;
  logic [LANES-1:0] ab_drive;
  logic [LANES-1:0] ba_drive;

  xcvr_core #(.LANE_W(LANE_W), .LANES(LANES)) u_core (
    .rst_n    (rst_n),
    .clk_ab   (clk_ab),
    .ce_ab_n  (ce_ab_n),
    .oe_ab_n  (oe_ab_n),
    .clk_ba   (clk_ba),
    .ce_ba_n  (ce_ba_n),
    .oe_ba_n  (oe_ba_n),
    .a_in     (a_io),
    .b_in     (b_io),
    .ab_q     (ab_q),
    .ab_drive (ab_drive),
    .ba_q     (ba_q),
    .ba_drive (ba_drive)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_pin
    assign b_io[g*LANE_W +: LANE_W] = ab_drive[g] ? ab_q[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};
    assign a_io[g*LANE_W +: LANE_W] = ba_drive[g] ? ba_q[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};

    // R4: an enabled lane shows the A-to-B store on the B pins
    a_r4_drive_b: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
      !oe_ab_n[g] |-> (b_io[g*LANE_W +: LANE_W] == ab_q[g*LANE_W +: LANE_W]));

    // R4: an enabled lane shows the B-to-A store on the A pins
    a_r4_drive_a: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
      !oe_ba_n[g] |-> (a_io[g*LANE_W +: LANE_W] == ba_q[g*LANE_W +: LANE_W]));
  end
endmodule

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  localparam int W = 8;
  localparam int L = 2;

  logic       clk;
  logic       rst_n;
  logic [1:0] clk_ab, ce_ab_n, oe_ab_n;
  logic [1:0] clk_ba, ce_ba_n, oe_ba_n;
  wire  [15:0] a_io;
  wire  [15:0] b_io;

  logic [7:0] a_val [L];
  logic [7:0] b_val [L];
  logic [1:0] a_en, b_en;
  logic [7:0] m_ab [L];
  logic [7:0] m_ba [L];

  int  vectors;
  int  miscompares;
  bit  done;

  typedef struct {
    int         side;   // 0: B bus, 1: A bus
    int         lane;
    logic [7:0] exp;
    bit         z;
    string      req;
  } item_t;
  item_t sbq [$];

  for (genvar g = 0; g < L; g++) begin : g_drv
    assign a_io[g*W +: W] = a_en[g] ? a_val[g] : 8'hzz;
    assign b_io[g*W +: W] = b_en[g] ? b_val[g] : 8'hzz;
  end

  reg_bus_xcvr dut (
    .rst_n   (rst_n),
    .clk_ab  (clk_ab),
    .ce_ab_n (ce_ab_n),
    .oe_ab_n (oe_ab_n),
    .clk_ba  (clk_ba),
    .ce_ba_n (ce_ba_n),
    .oe_ba_n (oe_ba_n),
    .a_io    (a_io),
    .b_io    (b_io)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic expect_bus(int side, int lane, logic [7:0] exp, bit z, string req);
    item_t it;
    it.side = side; it.lane = lane; it.z = z; it.req = req;
    it.exp  = z ? 8'hzz : exp;
    sbq.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    @(posedge clk);
  endtask

  // monitor: pops expected items and compares them away from the edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t      it;
        logic [7:0] act;
        it  = sbq.pop_front();
        act = (it.side == 1) ? a_io[it.lane*W +: W] : b_io[it.lane*W +: W];
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: %s bus lane %0d actual %h expected %h",
                   it.req, (it.side == 1) ? "A" : "B", it.lane, act, it.exp);
        end
      end
    end
  end

  task automatic tick_ab(int l, bit release_ce);
    @(posedge clk);
    if (!ce_ab_n[l]) m_ab[l] = a_en[l] ? a_val[l] : m_ba[l];
    clk_ab[l] = 1'b1;
    @(posedge clk);
    if (release_ce) ce_ab_n[l] = 1'b1;
    @(posedge clk);
    clk_ab[l] = 1'b0;
  endtask

  task automatic tick_ba(int l, bit release_ce);
    @(posedge clk);
    if (!ce_ba_n[l]) m_ba[l] = b_en[l] ? b_val[l] : m_ab[l];
    clk_ba[l] = 1'b1;
    @(posedge clk);
    if (release_ce) ce_ba_n[l] = 1'b1;
    @(posedge clk);
    clk_ba[l] = 1'b0;
  endtask

  task automatic tick_both(int l);
    logic [7:0] old_ab, old_ba;
    @(posedge clk);
    old_ab = m_ab[l]; old_ba = m_ba[l];
    m_ab[l] = old_ba;
    m_ba[l] = old_ab;
    clk_ab[l] = 1'b1;
    clk_ba[l] = 1'b1;
    @(posedge clk);
    ce_ab_n[l] = 1'b1;
    ce_ba_n[l] = 1'b1;
    @(posedge clk);
    clk_ab[l] = 1'b0;
    clk_ba[l] = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog (all): actual run still busy, expected completion");
      finish_run();
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    rst_n = 1'b0;
    clk_ab = '0; clk_ba = '0;
    ce_ab_n = 2'b11; ce_ba_n = 2'b11;
    oe_ab_n = 2'b11; oe_ba_n = 2'b11;
    a_en = '0; b_en = '0;
    for (int i = 0; i < L; i++) begin
      a_val[i] = '0; b_val[i] = '0; m_ab[i] = '0; m_ba[i] = '0;
    end
    repeat (3) @(posedge clk);

    // R5: drive enables high, buses released
    for (int l = 0; l < L; l++) begin
      expect_bus(0, l, 8'h00, 1'b1, "R5");
      expect_bus(1, l, 8'h00, 1'b1, "R5");
    end
    settle();

    // R9: stores cleared by reset
    rst_n = 1'b1;
    @(posedge clk);
    oe_ab_n = 2'b00; oe_ba_n = 2'b00;
    @(posedge clk);
    for (int l = 0; l < L; l++) begin
      expect_bus(0, l, 8'h00, 1'b0, "R9");
      expect_bus(1, l, 8'h00, 1'b0, "R9");
    end
    settle();
    oe_ab_n = 2'b11; oe_ba_n = 2'b11;
    @(posedge clk);

    for (int l = 0; l < L; l++) begin
      int o;
      o = 1 - l;

      // R1: A-to-B capture
      a_en[l] = 1'b1;
      a_val[l] = 8'(8'hA5 + 17 * l);
      ce_ab_n[l] = 1'b0;
      tick_ab(l, 1'b1);
      @(posedge clk);
      oe_ab_n = 2'b00;
      @(posedge clk);
      expect_bus(0, l, 8'(8'hA5 + 17 * l), 1'b0, "R1");
      expect_bus(0, o, m_ab[o], 1'b0, "R6");
      settle();
      oe_ab_n = 2'b11;
      @(posedge clk);
      expect_bus(0, l, 8'h00, 1'b1, "R5");
      settle();

      // R2: enable high, clock edges ignored
      a_val[l] = 8'h3C;
      tick_ab(l, 1'b0);
      tick_ab(l, 1'b0);
      oe_ab_n[l] = 1'b0;
      @(posedge clk);
      expect_bus(0, l, 8'(8'hA5 + 17 * l), 1'b0, "R2");
      settle();

      // R3: clock steady low, enable low, data moving
      ce_ab_n[l] = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk);
        a_val[l] = 8'(8'h10 * (k + 1) + l);
      end
      @(posedge clk);
      expect_bus(0, l, 8'(8'hA5 + 17 * l), 1'b0, "R3");
      settle();
      a_val[l] = 8'(8'h69 ^ l);
      tick_ab(l, 1'b1);
      @(posedge clk);
      expect_bus(0, l, 8'(8'h69 ^ l), 1'b0, "R1");
      settle();
      oe_ab_n[l] = 1'b1;

      // R1: B-to-A capture, then R4 onto the A bus
      b_en[l] = 1'b1;
      b_val[l] = 8'(8'hC3 - l);
      ce_ba_n[l] = 1'b0;
      tick_ba(l, 1'b1);
      @(posedge clk);
      a_en[l] = 1'b0;
      @(posedge clk);
      oe_ba_n[l] = 1'b0;
      @(posedge clk);
      expect_bus(1, l, 8'(8'hC3 - l), 1'b0, "R4");
      settle();

      // R7: both drive, both capture on one edge: bytes exchange
      b_en[l] = 1'b0;
      @(posedge clk);
      oe_ab_n[l] = 1'b0;
      @(posedge clk);
      ce_ab_n[l] = 1'b0;
      ce_ba_n[l] = 1'b0;
      tick_both(l);
      @(posedge clk);
      expect_bus(0, l, 8'(8'hC3 - l), 1'b0, "R7");
      expect_bus(1, l, 8'(8'h69 ^ l), 1'b0, "R7");
      settle();
      oe_ab_n[l] = 1'b1;
      oe_ba_n[l] = 1'b1;
      @(posedge clk);

      // R8: enable released while clock low captures
      a_en[l] = 1'b1;
      a_val[l] = 8'h11;
      ce_ab_n[l] = 1'b0;
      @(posedge clk);
      a_val[l] = 8'(8'hE7 + l);
      @(posedge clk);
      ce_ab_n[l] = 1'b1;
      m_ab[l] = a_val[l];
      @(posedge clk);
      oe_ab_n[l] = 1'b0;
      @(posedge clk);
      expect_bus(0, l, 8'(8'hE7 + l), 1'b0, "R8");
      settle();
      oe_ab_n[l] = 1'b1;
      a_en[l] = 1'b0;
      @(posedge clk);
    end

    // R9: reset in mid-run clears stores again
    rst_n = 1'b0;
    @(posedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < L; i++) begin
      m_ab[i] = '0; m_ba[i] = '0;
    end
    @(posedge clk);
    oe_ab_n = 2'b00; oe_ba_n = 2'b00;
    @(posedge clk);
    for (int l = 0; l < L; l++) begin
      expect_bus(0, l, 8'h00, 1'b0, "R9");
      expect_bus(1, l, 8'h00, 1'b0, "R9");
    end
    settle();
    @(posedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule